// File: doc/BRIEF.md
# Write-Only Two-Wire Clock Configuration Receiver

This block is a receive-only slave on a two-wire serial bus. It loads a small bank of clock-control registers. A faster system clock samples both bus lines through synchronizers. The block looks for start and stop conditions and compares the first byte after a start with its fixed device address. It acknowledges each byte it accepts by pulling the data line low. Software cannot read the registers back, and it cannot choose which register to write. After the address byte, the master sends two filler bytes, which are acknowledged and dropped. Every byte after those fills the registers in order, starting at register 0. To change register N, the master must therefore send registers 0 to N-1 again in the same transfer.

The register contents are presented as a flat output vector. Fields of register 0 are also decoded onto their own outputs: two frequency-select bits and a two-bit operating mode. A power-down input disables the bus logic while it is low. The stored register values are kept through power-down.

Top module: `cfg_i2c_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start. A rising data line while the clock line is high is a stop. After a stop the slave releases the data line and acknowledges nothing until the next start.
- R2: Bytes arrive MSB first over eight clock pulses. For an accepted byte, the slave holds `sda_pull` high from the falling edge after the eighth pulse until the falling edge of the ninth pulse.
- R3: The first byte after a start is accepted only when it equals 0xD2 (7-bit address 0x69, write bit 0). Any other value, including 0xD3 (read bit set), gets no acknowledge, and the slave ignores the bus until the next start.
- R4: The two bytes after an accepted address are acknowledged and change no register.
- R5: Later bytes of the transfer go to registers 0, 1, 2 and onward in order. Register k sits at bits [8k+7:8k] of `cfg_regs`.
- R6: Bytes after the last register are acknowledged and discarded.
- R7: A repeated start at any point returns the slave to address reception. The next write then begins at register 0 again.
- R8: While `pwrdn_n` is low the slave never pulls the data line and no register changes.
- R9: After reset, register 0 holds 0x0C and the other registers hold 0x00. `freq_sel` is register 0 bits [3:2] (1 selects the higher frequency). `clk_mode` is bits [1:0]: 00 normal, 01 test, 10 spread spectrum, 11 tri-state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Low disables the bus interface; registers are kept |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_pull | output | 1 | High drives the data line low (acknowledge) |
| cfg_regs | output | NUM_REGS*8 | Register bank; register k at bits [8k+7:8k] |
| freq_sel | output | 2 | Register 0 bits [3:2] |
| clk_mode | output | 2 | Register 0 bits [1:0] |

## Verification
The bench sends 0xD3, a near-miss of the address, and expects no acknowledge. A slave that ignored the read bit would accept that transfer and corrupt the registers. It also sends transfers longer than the register bank. A slave with a wrong index bound would wrap around and overwrite register 0, or would stop acknowledging. Other tests use repeated starts in the middle of data, transfers made only of filler bytes, and clocking after a stop with no new start. A slave that misses one of these would keep writing at a stale index, load the command byte into a register, or acknowledge while idle. Traffic sent during power-down must leave the bank unchanged and produce no acknowledge.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_BITS = 2'd1,
    RX_ACK  = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_CMD   = 2'd1,
    PH_COUNT = 2'd2,
    PH_DATA  = 2'd3
  } rx_phase_e;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh_q, sda_sh_q;
  logic [SYNC_STAGES-1:0] scl_sh_d, sda_sh_d;
  logic scl_d_q, sda_d_q;
  logic scl_s;

  // Shift the pad values through the synchronizer chain.
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb begin
        scl_sh_d = scl_i;
        sda_sh_d = sda_i;
      end
    end else begin : g_many
      always_comb begin
        scl_sh_d = {scl_sh_q[SYNC_STAGES-2:0], scl_i};
        sda_sh_d = {sda_sh_q[SYNC_STAGES-2:0], sda_i};
      end
    end
  endgenerate

  // Reset to the idle bus level, with both lines high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_d_q  <= 1'b1;
      sda_d_q  <= 1'b1;
    end else begin
      scl_sh_q <= scl_sh_d;
      sda_sh_q <= sda_sh_d;
      scl_d_q  <= scl_s;
      sda_d_q  <= sda_s;
    end
  end

  always_comb begin
    scl_s     = scl_sh_q[SYNC_STAGES-1];
    sda_s     = sda_sh_q[SYNC_STAGES-1];
    scl_rise  = scl_s & ~scl_d_q;
    scl_fall  = ~scl_s & scl_d_q;
    start_det = scl_s & scl_d_q & sda_d_q & ~sda_s;
    stop_det  = scl_s & scl_d_q & ~sda_d_q & sda_s;
  end
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 4,
  parameter int         IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_pull,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  localparam logic [7:0]       ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(NUM_REGS);

  rx_state_e        state_q, state_d;
  rx_phase_e        phase_q, phase_d;
  logic [3:0]       bits_q, bits_d;
  logic [7:0]       shreg_q, shreg_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pull_q, pull_d;
  logic             wr_en_c;

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bits_d  = bits_q;
    shreg_d = shreg_q;
    idx_d   = idx_q;
    pull_d  = pull_q;
    wr_en_c = 1'b0;
    if (!enable) begin
      state_d = RX_IDLE;
      pull_d  = 1'b0;
    end else if (start_det) begin
      state_d = RX_BITS;
      phase_d = PH_ADDR;
      bits_d  = 4'd0;
      idx_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      state_d = RX_IDLE;
      pull_d  = 1'b0;
    end else begin
      case (state_q)
        RX_BITS: begin
          if (scl_rise && bits_q < 4'd8) begin
            shreg_d = {shreg_q[6:0], sda_s};
            bits_d  = bits_q + 4'd1;
          end else if (scl_fall && bits_q == 4'd8) begin
            if (phase_q == PH_ADDR && shreg_q != ADDR_BYTE) begin
              state_d = RX_IDLE;
            end else begin
              state_d = RX_ACK;
              pull_d  = 1'b1;
              if (phase_q == PH_DATA && idx_q < IDX_END) wr_en_c = 1'b1;
            end
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            state_d = RX_BITS;
            bits_d  = 4'd0;
            pull_d  = 1'b0;
            if (phase_q != PH_DATA) phase_d = rx_phase_e'(phase_q + 2'd1);
            else if (idx_q < IDX_END) idx_d = idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      phase_q <= PH_ADDR;
      bits_q  <= 4'd0;
      shreg_q <= 8'h00;
      idx_q   <= '0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bits_q  <= bits_d;
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      pull_q  <= pull_d;
    end
  end

  always_comb begin
    sda_pull = pull_q;
    wr_en    = wr_en_c;
    wr_idx   = idx_q;
    wr_data  = shreg_q;
  end
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file #(
  parameter int         NUM_REGS   = 4,
  parameter int         IDX_W      = $clog2(NUM_REGS + 1),
  parameter logic [7:0] REG0_INIT  = 8'h0C,
  parameter logic [7:0] OTHER_INIT = 8'h00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs
);
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] INIT = (g == 0) ? REG0_INIT : OTHER_INIT;
      logic [7:0] val_q;
      logic       ce;
      always_comb ce = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  val_q <= INIT;
        else if (ce) val_q <= wr_data;
      end
      always_comb regs[g*8 +: 8] = val_q;
    end
  endgenerate
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] REG0_INIT   = 8'h0C,
  parameter logic [7:0] OTHER_INIT  = 8'h00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwrdn_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull,
  output logic [NUM_REGS*8-1:0] cfg_regs,
  output logic [1:0]            freq_sel,
  output logic [1:0]            clk_mode
);
  localparam int IDX_W = $clog2(NUM_REGS + 1);

  logic             rst_meta_q, rst_n_sync;
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  // Reset is asserted asynchronously and released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n_sync), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_wr_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_sync), .enable(pwrdn_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_pull(sda_pull), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_reg_file #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .REG0_INIT(REG0_INIT),
                 .OTHER_INIT(OTHER_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs(cfg_regs)
  );

  always_comb begin
    freq_sel = cfg_regs[3:2];
    clk_mode = cfg_regs[1:0];
  end
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwrdn_n,
  input logic             sda_pull,
  input logic             scl_fall,
  input logic             stop_det,
  input logic [CFG_W-1:0] cfg_regs
);
  // An acknowledge only starts on a falling bus clock.
  assert_ack_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  // A stop releases the data line.
  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  // Power-down releases the data line.
  assert_pd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> !sda_pull);

  // Power-down holds the register bank.
  assert_pd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> $stable(cfg_regs));

  // Registers are written only on a falling bus clock.
  assert_write_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_regs) |-> $past(scl_fall));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.CFG_W(NUM_REGS*8)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .pwrdn_n(pwrdn_n), .sda_pull(sda_pull),
  .scl_fall(scl_fall), .stop_det(stop_det), .cfg_regs(cfg_regs)
);

// File: tb/sim_cfg_i2c_slave.sv
module sim_cfg_i2c_slave;
  localparam int NREG = 4;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rst_n, pwrdn_n, scl_m, sda_m;
  logic sda_pull;
  logic [NREG*8-1:0] cfg_regs;
  logic [1:0] freq_sel, clk_mode;
  logic sda_bus;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_reg [NREG];
  logic [7:0] tx [16];

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  cfg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull(sda_pull), .cfg_regs(cfg_regs), .freq_sel(freq_sel), .clk_mode(clk_mode)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(2*Q); sda_m = 1'b0; w(2*Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(2*Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic bus_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    ack = (sda_bus == 1'b0);
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  function automatic bit exp_ack(input logic [7:0] addr);
    return pwrdn_n && (addr == 8'hD2);
  endfunction

  // Send tx[0..n-1] after a start; check every acknowledge and update the model.
  task automatic xfer(input int n, input bit do_stop, input string req);
    bit a;
    bit e;
    e = exp_ack(tx[0]);
    bus_start();
    for (int i = 0; i < n; i++) begin
      bus_byte(tx[i], a);
      chk(a == e, req, {31'd0, a}, {31'd0, e});
      if (e && i >= 3 && (i - 3) < NREG) exp_reg[i-3] = tx[i];
    end
    if (do_stop) bus_stop();
  endtask

  task automatic chk_regs(input string req);
    for (int k = 0; k < NREG; k++)
      chk(cfg_regs[k*8 +: 8] == exp_reg[k], req, {24'd0, cfg_regs[k*8 +: 8]}, {24'd0, exp_reg[k]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit a;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; pwrdn_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    exp_reg[0] = 8'h0C;
    for (int k = 1; k < NREG; k++) exp_reg[k] = 8'h00;
    w(5); rst_n = 1'b1; w(5);

    // R9: reset values and decoded fields
    chk_regs("R9");
    chk(freq_sel == 2'b11, "R9", {30'd0, freq_sel}, 32'd3);
    chk(clk_mode == 2'b00, "R9", {30'd0, clk_mode}, 32'd0);

    // R4 R5: filler bytes dropped, first data byte lands in register 0
    tx[0] = 8'hD2; tx[1] = 8'h55; tx[2] = 8'hAA; tx[3] = 8'hA5;
    xfer(4, 1, "R4/R5 ack");
    chk_regs("R5");
    chk(clk_mode == 2'b01, "R9", {30'd0, clk_mode}, 32'd1);
    chk(freq_sel == 2'b01, "R9", {30'd0, freq_sel}, 32'd1);

    // R4: filler bytes only
    tx[1] = 8'hFF; tx[2] = 8'hFF;
    xfer(3, 1, "R4 ack");
    chk_regs("R4");

    // R6: run past the last register
    tx[3] = 8'h11; tx[4] = 8'h22; tx[5] = 8'h33; tx[6] = 8'h44; tx[7] = 8'h99; tx[8] = 8'h77;
    xfer(9, 1, "R6 ack");
    chk_regs("R6");

    // R3: read bit set, and a wrong address
    tx[0] = 8'hD3; tx[3] = 8'hEE; xfer(5, 1, "R3 read-bit nack");
    chk_regs("R3");
    tx[0] = 8'h52; xfer(5, 1, "R3 wrong-addr nack");
    chk_regs("R3");

    // R1: after a stop, clocking a byte with no start gets no acknowledge
    tx[0] = 8'hD2; xfer(1, 1, "R1 ack");
    bus_byte(8'hFF, a);
    chk(a == 1'b0, "R1", {31'd0, a}, 32'd0);
    bus_stop();

    // R7: repeated start mid-data restarts at register 0
    tx[0] = 8'hD2; tx[3] = 8'h3C; tx[4] = 8'h4D;
    xfer(5, 0, "R7 ack");
    tx[3] = 8'h6E;
    xfer(4, 1, "R7 ack");
    chk_regs("R7");

    // R8: power-down ignores the bus and keeps the registers
    pwrdn_n = 1'b0; w(4);
    tx[3] = 8'h01; tx[4] = 8'h02;
    xfer(5, 1, "R8 nack");
    chk_regs("R8");
    pwrdn_n = 1'b1; w(4);

    // Random traffic (R2 R3 R5 R6 R7)
    for (int t = 0; t < 30; t++) begin
      int sel;
      int n;
      sel = $urandom % 4;
      tx[0] = (sel < 2) ? 8'hD2 : (sel == 2) ? 8'hD3 : 8'($urandom);
      n = 1 + ($urandom % 8);
      for (int i = 1; i < n; i++) tx[i] = 8'($urandom);
      xfer(n, ($urandom % 4) != 0, "R2 random ack");
      chk_regs("R5 random");
    end
    bus_stop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule